// File: doc/BRIEF.md
# Path Signal Label Monitor

This block watches the path signal label byte that arrives once per frame and sets two alarms, each with a persistence filter. A label is accepted as correct when it equals the expected value that the host programs. A fixed hardware label of 01H is also accepted unless a disable control is set. Five consecutive frames with a wrong label raise the mismatch alarm. Five consecutive frames with a correct label clear it.

A separate filter handles the unequipped alarm. Five consecutive all-zero labels raise it, and five consecutive non-zero labels clear it. An all-zero label never counts toward the mismatch alarm. This keeps an unequipped path from also being reported as a mismatch.

An inhibit input is driven from the OR of the upstream path alarms: loss of the J1 pulse, E1 AIS, loss of pointer and path AIS. While inhibit is high, both filters are held at zero and both alarms are forced low. The last label taken while not inhibited is presented at an output. The input `frame_stb` is one clock wide, once per frame, and qualifies `rx_label`.

Top module: `psl_monitor`

## Requirements
- R1: After a synchronous active-low reset, both alarms are low and `accepted_label` is 00H.
- R2: A label equal to `exp_label` is a correct label.
- R3: While `fixed_dis` is 0, a label of 01H is also a correct label.
- R4: While `fixed_dis` is 1, 01H is correct only if it equals `exp_label`.
- R5: The mismatch alarm rises on the fifth consecutive strobed frame whose label is wrong and non-zero.
- R6: The mismatch alarm falls on the fifth consecutive strobed frame whose label is not counted as wrong.
- R7: Any frame that breaks a run restarts that run from zero.
- R8: The unequipped alarm rises on the fifth consecutive strobed frame with label 00H.
- R9: The unequipped alarm falls on the fifth consecutive strobed frame with a non-zero label.
- R10: A 00H label never advances or triggers the mismatch alarm.
- R11: While `inhibit` is high, both alarms read low in that same cycle. Both runs and both alarm states return to zero.
- R12: The filters change only on cycles where `frame_stb` is high.
- R13: `accepted_label` takes `rx_label` on each strobed cycle without inhibit and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | One pulse per frame qualifying rx_label |
| rx_label | input | 8 | Received signal label byte |
| exp_label | input | 8 | Host-programmed expected label |
| fixed_dis | input | 1 | 1 disables acceptance of the fixed 01H label |
| inhibit | input | 1 | OR of upstream path alarms |
| mismatch_alarm | output | 1 | Label mismatch alarm |
| uneq_alarm | output | 1 | Unequipped alarm |
| accepted_label | output | 8 | Label of the last accepted frame |

## Verification
An alarm changes at the clock edge that samples the fifth qualifying strobe, so it is visible one cycle after that strobe is driven. `accepted_label` follows the same one-edge delay. The inhibit masking has no delay and shows in the cycle where inhibit is high. The bench drives its inputs on falling edges and updates a run-count model on each rising edge. It compares all three outputs 1 ns after every rising edge, which places each result in the exact cycle it is due.

// File: rtl/psl_monitor.sv
module psl_monitor #(
  parameter int                 LABEL_W     = 8,
  parameter int                 PERSIST     = 5,
  parameter logic [LABEL_W-1:0] FIXED_LABEL = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_stb,
  input  logic [LABEL_W-1:0] rx_label,
  input  logic [LABEL_W-1:0] exp_label,
  input  logic               fixed_dis,
  input  logic               inhibit,
  output logic               mismatch_alarm,
  output logic               uneq_alarm,
  output logic [LABEL_W-1:0] accepted_label
);
  localparam int CW = $clog2(PERSIST + 1);
  localparam logic [CW-1:0] LAST = CW'(PERSIST - 1);

  logic          mm_q, uq_q;
  logic [CW-1:0] mm_cnt, uq_cnt;
  logic [LABEL_W-1:0] lbl_q;

  wire is_prog  = (rx_label == exp_label);
  wire is_fixed = !fixed_dis && (rx_label == FIXED_LABEL);
  wire is_zero  = (rx_label == '0);
  wire is_bad   = !(is_prog || is_fixed) && !is_zero;

  wire mm_flip = is_bad ^ mm_q;
  wire uq_flip = is_zero ^ uq_q;

  always_ff @(posedge clk) begin
    if (!rst_n || inhibit) begin
      mm_q   <= 1'b0;
      uq_q   <= 1'b0;
      mm_cnt <= '0;
      uq_cnt <= '0;
      if (!rst_n) lbl_q <= '0;
    end else if (frame_stb) begin
      lbl_q <= rx_label;
      if (!mm_flip) mm_cnt <= '0;
      else if (mm_cnt == LAST) begin
        mm_q   <= ~mm_q;
        mm_cnt <= '0;
      end else mm_cnt <= mm_cnt + 1'b1;
      if (!uq_flip) uq_cnt <= '0;
      else if (uq_cnt == LAST) begin
        uq_q   <= ~uq_q;
        uq_cnt <= '0;
      end else uq_cnt <= uq_cnt + 1'b1;
    end
  end

  assign mismatch_alarm = mm_q && !inhibit;
  assign uneq_alarm     = uq_q && !inhibit;
  assign accepted_label = lbl_q;
endmodule

// File: rtl/psl_monitor_chk.sv
module psl_monitor_chk #(
  parameter int LABEL_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_stb,
  input logic [LABEL_W-1:0] rx_label,
  input logic               inhibit,
  input logic               mismatch_alarm,
  input logic               uneq_alarm,
  input logic [LABEL_W-1:0] accepted_label
);
  assert_inhibit_masks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (!mismatch_alarm && !uneq_alarm));

  assert_mm_rise_on_stb_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch_alarm) |-> $past(frame_stb));

  assert_uq_rise_on_stb_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uneq_alarm) |-> $past(frame_stb));

  assert_zero_never_mismatch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch_alarm) |-> ($past(rx_label) != '0));

  assert_uneq_from_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uneq_alarm) |-> ($past(rx_label) == '0));

  assert_label_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_stb) |-> $stable(accepted_label));
endmodule

bind psl_monitor psl_monitor_chk #(.LABEL_W(LABEL_W)) u_chk (.*);

// File: tb/tb_psl_monitor.sv
`timescale 1ns/1ps
module tb_psl_monitor;
  logic clk = 0, rst_n = 0, frame_stb = 0, fixed_dis = 0, inhibit = 0;
  logic [7:0] rx_label = 0, exp_label = 8'h35;
  logic mismatch_alarm, uneq_alarm;
  logic [7:0] accepted_label;
  int tests = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  psl_monitor dut (.*);

  int bad_run = 0, good_run = 0, zero_run = 0, nz_run = 0;
  bit m_mm = 0, m_uq = 0;
  logic [7:0] m_lbl = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      bad_run = 0; good_run = 0; zero_run = 0; nz_run = 0;
      m_mm = 0; m_uq = 0; m_lbl = 0;
    end else if (inhibit) begin
      bad_run = 0; good_run = 0; zero_run = 0; nz_run = 0;
      m_mm = 0; m_uq = 0;
    end else if (frame_stb) begin
      bit ok, bad;
      m_lbl = rx_label;
      ok  = (rx_label == exp_label) || (!fixed_dis && rx_label == 8'h01);
      bad = !ok && (rx_label != 0);
      if (bad) begin bad_run++; good_run = 0; end
      else begin good_run++; bad_run = 0; end
      if (!m_mm && bad_run >= 5) begin m_mm = 1; bad_run = 0; end
      else if (m_mm && good_run >= 5) begin m_mm = 0; good_run = 0; end
      if (rx_label == 0) begin zero_run++; nz_run = 0; end
      else begin nz_run++; zero_run = 0; end
      if (!m_uq && zero_run >= 5) begin m_uq = 1; zero_run = 0; end
      else if (m_uq && nz_run >= 5) begin m_uq = 0; nz_run = 0; end
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk); #1;
    if (rst_n && !done) begin
      check(cur_req, {7'b0, mismatch_alarm}, {7'b0, m_mm && !inhibit}, "mismatch_alarm");
      check(cur_req, {7'b0, uneq_alarm}, {7'b0, m_uq && !inhibit}, "uneq_alarm");
      check(cur_req, accepted_label, m_lbl, "accepted_label");
    end
  end

  task automatic frame(logic [7:0] lbl);
    @(negedge clk); rx_label = lbl; frame_stb = 1;
    @(negedge clk); frame_stb = 0; rx_label = 8'hA5;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic frames(logic [7:0] lbl, int n);
    for (int i = 0; i < n; i++) frame(lbl);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", {6'b0, mismatch_alarm, uneq_alarm}, 8'h00, "alarms after reset");
    check("R1", accepted_label, 8'h00, "label after reset");

    cur_req = "R2"; frames(8'h35, 6);
    check("R2", {7'b0, mismatch_alarm}, 0, "programmed label matches");
    cur_req = "R3"; frames(8'h01, 6);
    check("R3", {7'b0, mismatch_alarm}, 0, "fixed 01H matches");
    cur_req = "R7"; frames(8'h77, 4); frame(8'h35);
    check("R7", {7'b0, mismatch_alarm}, 0, "broken bad run");
    cur_req = "R5"; frames(8'h77, 4);
    check("R5", {7'b0, mismatch_alarm}, 0, "four bad frames");
    frame(8'h77);
    check("R5", {7'b0, mismatch_alarm}, 1, "fifth bad frame");
    check("R13", accepted_label, 8'h77, "accepted label");
    cur_req = "R7"; frames(8'h35, 4); frame(8'h77);
    check("R7", {7'b0, mismatch_alarm}, 1, "broken good run");
    cur_req = "R6"; frames(8'h35, 5);
    check("R6", {7'b0, mismatch_alarm}, 0, "cleared after five good");
    cur_req = "R4"; fixed_dis = 1; frames(8'h01, 5);
    check("R4", {7'b0, mismatch_alarm}, 1, "01H wrong when fixed disabled");
    frames(8'h35, 5);
    check("R4", {7'b0, mismatch_alarm}, 0, "recover");
    cur_req = "R8"; frames(8'h00, 4);
    check("R8", {7'b0, uneq_alarm}, 0, "four zeros");
    frame(8'h00);
    check("R8", {7'b0, uneq_alarm}, 1, "fifth zero");
    cur_req = "R10"; frames(8'h00, 6);
    check("R10", {7'b0, mismatch_alarm}, 0, "zero never mismatches");
    cur_req = "R9"; frames(8'h35, 4); frame(8'h00); frames(8'h35, 4);
    check("R9", {7'b0, uneq_alarm}, 1, "run broken");
    frame(8'h35);
    check("R9", {7'b0, uneq_alarm}, 0, "cleared after five non-zero");
    cur_req = "R11"; fixed_dis = 0; frames(8'h77, 5);
    @(negedge clk); inhibit = 1; #1;
    check("R11", {7'b0, mismatch_alarm}, 0, "masked at once");
    frames(8'h00, 6);
    check("R11", {6'b0, mismatch_alarm, uneq_alarm}, 0, "inhibited frames");
    check("R13", accepted_label, 8'h77, "label held while inhibited");
    inhibit = 0; frames(8'h77, 4);
    check("R11", {7'b0, mismatch_alarm}, 0, "restart from zero");
    frame(8'h77);
    check("R11", {7'b0, mismatch_alarm}, 1, "redeclared");
    cur_req = "R12";
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); rx_label = (i % 2) ? 8'h35 : 8'h00;
    end
    @(negedge clk);
    check("R12", {6'b0, mismatch_alarm, uneq_alarm}, 8'h02, "no strobe no change");
    check("R12", accepted_label, 8'h77, "label unchanged without strobe");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule